// File: doc/BRIEF.md
# Audio Control Register Slave with Write-Only I2C Access

This block lets a host program the control registers of an audio processor over a two-wire I2C bus. The host can only write. The block oversamples SCL and SDA with the system clock and cleans both lines. It detects START and STOP conditions and accepts an address byte whose seventh bit is set by a strap pin. After that it takes a subaddress byte and stores the data bytes that follow into a bank of 8-bit function registers. Every register drives a parallel output, so the analog stages can read its contents directly.

The subaddress picks a 4-bit slot index and can turn on auto-increment. When auto-increment is on, each data byte goes to the next slot in turn. The index wraps after 15, and slots 10 to 15 take no data. When auto-increment is off, every data byte goes to the same slot. Slot 2 has no register and always reads zero. The block drives an acknowledge on every byte it accepts. It does not depend on the master checking that acknowledge, so bytes may be sent back to back.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset the slots read as follows. Slot 0 (input attenuation) is 0x3F, which is full attenuation. Slot 1 (L+R and subwoofer) is 0x7E, which means L+R level lowest, output FIX, subwoofer off. Slot 2 is 0x00. Slot 3 (bass) is 0x0E, with natural bass off. Slot 4 (middle and treble) is 0xE7. Slots 5 to 8 (speaker L/R and aux L/R) are 0x58, the mute code. Slot 9 (input selector) is 0x06, which selects input 1.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. While SCL is low, SDA changes are data, and each bit is sampled MSB first on the SCL rising edge. A register changes only while SCL is low, after the eighth bit of its byte.
- R3: The address byte {1,0,0,0,0,0,strap,0} (MSB first) is acknowledged. `sda_drive_o` goes high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth bit.
- R4: If the address byte differs in any bit, including the strap bit or the write bit (LSB = 1), it gets no acknowledge. The block then ignores the bus and writes nothing until the next START.
- R5: The subaddress byte is acknowledged. Bit 7 set to 1 turns on auto-increment, bits 3:0 give the slot index, and bits 6:4 are ignored.
- R6: With auto-increment off, every data byte up to the STOP is written to the one selected slot, and each byte is acknowledged.
- R7: With auto-increment on, each data byte goes to the current index, and then the index steps by one modulo 16. Bytes that land on indices 10 to 15 are acknowledged, but they change no register.
- R8: Bytes aimed at slot 2 are acknowledged, but they change no output. Slot 2 always reads 0x00.
- R9: A START or a STOP in the middle of a byte drops that byte without writing it. After a repeated START, the block matches the address again.
- R10: A pulse one system clock long on SCL or SDA is filtered out. It causes no START, no STOP, no shifted bit and no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| addr_strap_i | input | 1 | Address bit 1 that the block answers to |
| sda_drive_o | output | 1 | 1 pulls SDA low (the acknowledge) |
| regs_o | output | NUM_SLOTS*DW | Slot contents; slot i is bits [8i+7:8i] |

## Verification
If the slot pointer is wrong, the wrong slot output changes at the SCL falling edge after the eighth bit of that same data byte. If the protocol phase or the bit counter is wrong, `sda_drive_o` shows it within one byte, as a missing or extra acknowledge, or one in the wrong bit position. The bench compares every slot and the acknowledge line against its model on each clock, except for a short settling window after each change on the bus. As a result, a fault appears a few system clocks after the bus edge that exposes it.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

    localparam int DATA_W      = 8;
    localparam int NUM_SLOTS   = 10;
    localparam int IDX_W       = 4;
    localparam int UNUSED_SLOT = 2;
    localparam logic [5:0] ADDR_HI = 6'b100000;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic             autoinc;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic [DATA_W-1:0] slot_reset(input int slot);
        case (slot)
            0:       return 8'h3F;
            1:       return 8'h7E;
            3:       return 8'h0E;
            4:       return 8'hE7;
            5, 6, 7, 8: return 8'h58;
            9:       return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [NUM_SLOTS*DATA_W-1:0] reset_image();
        logic [NUM_SLOTS*DATA_W-1:0] img;
        img = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            img[i*DATA_W +: DATA_W] = slot_reset(i);
        end
        return img;
    endfunction

endpackage

// File: rtl/audio_ctl_line_filter.sv
module audio_ctl_line_filter #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] sync_q;
    logic              hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hold_q  <= 1'b1;
            level_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            hold_q <= sync_q[STAGES-1];
            if (sync_q[STAGES-1] == hold_q) begin
                level_o <= hold_q;
            end
        end
    end
endmodule

// File: rtl/audio_ctl_byte_engine.sv
module audio_ctl_byte_engine
    import audio_ctl_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic             strap_i,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [DW-1:0]    wr_data,
    output logic             ack_o
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    logic       scl_q, sda_q;
    bus_ev_t    ev;
    phase_e     phase;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       in_ack;
    ptr_t       ptr;
    logic       byte_done;
    logic       addr_ok;
    logic       slot_ok;

    always_comb begin
        ev.start = scl_q & scl_f & sda_q & ~sda_f;
        ev.stop  = scl_q & scl_f & ~sda_q & sda_f;
        ev.rise  = ~scl_q & scl_f;
        ev.fall  = scl_q & ~scl_f;
    end

    assign byte_done = ev.fall && !in_ack && (bitcnt == LAST_BIT) && (phase != PH_IDLE);
    assign addr_ok   = (shreg == {ADDR_HI, strap_i, 1'b0});
    assign slot_ok   = (int'(ptr.idx) < NSLOT) && (int'(ptr.idx) != UNUSED_SLOT);

    assign wr_en   = byte_done && (phase == PH_DATA) && slot_ok && !ev.start && !ev.stop;
    assign wr_idx  = ptr.idx;
    assign wr_data = shreg[DW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            phase  <= PH_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            in_ack <= 1'b0;
            ack_o  <= 1'b0;
            ptr    <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (ev.start) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                in_ack <= 1'b0;
                ack_o  <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                in_ack <= 1'b0;
                ack_o  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.rise && !in_ack && bitcnt != LAST_BIT) begin
                    shreg  <= {shreg[6:0], sda_f};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (ev.fall && in_ack) begin
                    in_ack <= 1'b0;
                    ack_o  <= 1'b0;
                    bitcnt <= '0;
                end else if (byte_done) begin
                    case (phase)
                        PH_ADDR: begin
                            if (addr_ok) begin
                                ack_o  <= 1'b1;
                                in_ack <= 1'b1;
                                phase  <= PH_SUB;
                            end else begin
                                phase  <= PH_IDLE;
                                bitcnt <= '0;
                            end
                        end
                        PH_SUB: begin
                            ptr.autoinc <= shreg[7];
                            ptr.idx     <= shreg[IDX_W-1:0];
                            ack_o       <= 1'b1;
                            in_ack      <= 1'b1;
                            phase       <= PH_DATA;
                        end
                        default: begin
                            if (ptr.autoinc) begin
                                ptr.idx <= ptr.idx + 1'b1;
                            end
                            ack_o  <= 1'b1;
                            in_ack <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/audio_ctl_reg_bank.sv
module audio_ctl_reg_bank
    import audio_ctl_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int DW    = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [NSLOT*DW-1:0] regs_o
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i == UNUSED_SLOT) begin : g_hole
            assign regs_o[i*DW +: DW] = '0;
        end else begin : g_reg
            logic [DW-1:0] val_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    val_q <= DW'(slot_reset(i));
                end else if (wr_en && int'(wr_idx) == i) begin
                    val_q <= wr_data;
                end
            end
            assign regs_o[i*DW +: DW] = val_q;
        end
    end
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
    import audio_ctl_pkg::*;
#(
    parameter int NUM_SLOTS   = audio_ctl_pkg::NUM_SLOTS,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    addr_strap_i,
    output logic                    sda_drive_o,
    output logic [NUM_SLOTS*DW-1:0] regs_o
);
    logic             scl_f, sda_f;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DW-1:0]    wr_data;

    audio_ctl_line_filter #(.STAGES(SYNC_STAGES)) u_scl_filt (
        .clk(clk), .rst(rst), .pin_i(scl_i), .level_o(scl_f)
    );

    audio_ctl_line_filter #(.STAGES(SYNC_STAGES)) u_sda_filt (
        .clk(clk), .rst(rst), .pin_i(sda_i), .level_o(sda_f)
    );

    audio_ctl_byte_engine #(.NSLOT(NUM_SLOTS), .DW(DW)) u_engine (
        .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
        .strap_i(addr_strap_i), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .ack_o(sda_drive_o)
    );

    audio_ctl_reg_bank #(.NSLOT(NUM_SLOTS), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_o(regs_o)
    );
endmodule

// File: rtl/audio_ctl_i2c_sva.sv
module audio_ctl_i2c_sva
    import audio_ctl_pkg::*;
#(
    parameter int NS = audio_ctl_pkg::NUM_SLOTS,
    parameter int DW = DATA_W
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_i,
    input logic             sda_drive_o,
    input logic [NS*DW-1:0] regs_o
);
    localparam logic [NS*DW-1:0] RST_IMG = (NS*DW)'(reset_image());

    // R1: first cycle out of reset shows the power-on image
    a_r1_reset_image: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> regs_o == RST_IMG);

    // R3: acknowledge starts only while SCL is low
    a_r3_ack_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_o) |-> !scl_i);

    // R3: acknowledge is released only while SCL is low
    a_r3_ack_fall_scl_low: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_drive_o) |-> !scl_i);

    // R2: slot contents change only in the SCL low phase
    a_r2_write_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_o) |-> !scl_i);

    // R2: no write lands while the block holds the acknowledge high
    a_r2_no_write_mid_ack: assert property (@(posedge clk) disable iff (rst)
        (sda_drive_o && $past(sda_drive_o)) |-> $stable(regs_o));
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_sva #(.NS(NUM_SLOTS), .DW(DW)) u_sva (
    .clk(clk), .rst(rst), .scl_i(scl_i),
    .sda_drive_o(sda_drive_o), .regs_o(regs_o)
);

// File: tb/tb_audio_ctl_i2c_slave.sv
`timescale 1ns/1ps
module tb_audio_ctl_i2c_slave;
    localparam int NS = 10;
    localparam int H  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_drive_o;
    logic [NS*8-1:0] regs_o;
    wire  sda_line = sda_m & ~sda_drive_o;

    always #2 clk = ~clk;

    audio_ctl_i2c_slave dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .addr_strap_i(strap), .sda_drive_o(sda_drive_o), .regs_o(regs_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_reg [NS];
    logic exp_ack = 1'b0;
    int m_phase = 0;
    logic m_inc = 1'b0;
    int m_idx = 0;
    string cur_req = "R1";
    logic run_cmp = 1'b0;
    int quiet = 0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int cycles = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // per-clock comparison against the model, away from both edges
    always @(posedge clk) begin
        #1;
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
        if (scl_m !== prev_scl || sda_m !== prev_sda) quiet = 0;
        else quiet++;
        prev_scl = scl_m;
        prev_sda = sda_m;
        if (run_cmp && quiet >= 8) begin
            for (int i = 0; i < NS; i++) begin
                if (regs_o[i*8 +: 8] !== exp_reg[i]) chk(cur_req, regs_o[i*8 +: 8], exp_reg[i]);
            end
            chk(cur_req, sda_drive_o, exp_ack);
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_byte(input logic [7:0] b);
        case (m_phase)
            1: begin
                if (b == {6'b100000, strap, 1'b0}) begin
                    exp_ack = 1'b1;
                    m_phase = 2;
                end else begin
                    m_phase = 0;
                end
            end
            2: begin
                m_inc = b[7];
                m_idx = int'(b[3:0]);
                exp_ack = 1'b1;
                m_phase = 3;
            end
            3: begin
                if (m_idx < NS && m_idx != 2) exp_reg[m_idx] = b;
                if (m_inc) m_idx = (m_idx + 1) % 16;
                exp_ack = 1'b1;
            end
            default: exp_ack = 1'b0;
        endcase
    endfunction

    task automatic bus_start();
        sda_m = 1'b0; m_phase = 1; exp_ack = 1'b0;
        wclk(H);
        scl_m = 1'b0;
        wclk(H);
    endtask

    task automatic bus_rep_start();
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H);
        bus_start();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b1; m_phase = 0; exp_ack = 1'b0;
        wclk(H);
    endtask

    // glitch: 0 none, 1 one-clock SDA pulse, 2 one-clock SCL low pulse
    task automatic send_bit(input logic b, input int glitch);
        wclk(4);
        sda_m = b;
        wclk(H - 4);
        scl_m = 1'b1;
        wclk(H / 2);
        if (glitch == 1) begin sda_m = ~b; wclk(1); sda_m = b; end
        if (glitch == 2) begin scl_m = 1'b0; wclk(1); scl_m = 1'b1; end
        wclk(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag, input int gbit, input int gkind);
        logic ack_seen;
        for (int k = 7; k >= 0; k--) send_bit(b[k], (k == gbit) ? gkind : 0);
        ack_seen = (m_phase != 0);
        model_byte(b);
        wclk(4);
        sda_m = 1'b1;
        wclk(H - 4);
        scl_m = 1'b1;
        wclk(H / 2);
        if (ack_seen || m_phase == 0) chk(tag, sda_drive_o, exp_ack);
        wclk(H / 2);
        scl_m = 1'b0;
        exp_ack = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int k = 7; k > 7 - n; k--) send_bit(b[k], 0);
    endtask

    initial begin
        exp_reg[0] = 8'h3F; exp_reg[1] = 8'h7E; exp_reg[2] = 8'h00;
        exp_reg[3] = 8'h0E; exp_reg[4] = 8'hE7; exp_reg[5] = 8'h58;
        exp_reg[6] = 8'h58; exp_reg[7] = 8'h58; exp_reg[8] = 8'h58;
        exp_reg[9] = 8'h06;
        wclk(6);
        rst = 1'b0;
        wclk(2);
        // R1: reset image
        for (int i = 0; i < NS; i++) chk("R1", regs_o[i*8 +: 8], exp_reg[i]);
        chk("R1", sda_drive_o, 1'b0);
        run_cmp = 1'b1;

        // R3 / R6: single-slot writes, last byte wins
        cur_req = "R6";
        bus_start();
        send_byte(8'h80, "R3", -1, 0);
        send_byte(8'h05, "R5", -1, 0);
        send_byte(8'h12, "R6", -1, 0);
        send_byte(8'h34, "R6", -1, 0);
        send_byte(8'h9A, "R6", -1, 0);
        bus_stop();
        chk("R6", regs_o[5*8 +: 8], 8'h9A);
        chk("R6", regs_o[6*8 +: 8], 8'h58);

        // R5: don't-care bits 6:4 set, increment off
        cur_req = "R5";
        bus_start();
        send_byte(8'h80, "R3", -1, 0);
        send_byte(8'h73, "R5", -1, 0);
        send_byte(8'h11, "R5", -1, 0);
        bus_stop();
        chk("R5", regs_o[3*8 +: 8], 8'h11);

        // R7: increment with skip range and wrap
        cur_req = "R7";
        bus_start();
        send_byte(8'h80, "R3", -1, 0);
        send_byte(8'hC8, "R7", -1, 0);
        for (int j = 0; j < 10; j++) send_byte(8'hA0 + 8'(j), "R7", -1, 0);
        bus_stop();
        chk("R7", regs_o[8*8 +: 8], 8'hA0);
        chk("R7", regs_o[9*8 +: 8], 8'hA1);
        chk("R7", regs_o[0*8 +: 8], 8'hA8);
        chk("R7", regs_o[1*8 +: 8], 8'hA9);

        // R8: unused slot
        cur_req = "R8";
        bus_start();
        send_byte(8'h80, "R3", -1, 0);
        send_byte(8'h02, "R8", -1, 0);
        send_byte(8'hAA, "R8", -1, 0);
        bus_stop();
        chk("R8", regs_o[2*8 +: 8], 8'h00);

        // R4: wrong strap bit and read bit
        cur_req = "R4";
        bus_start();
        send_byte(8'h82, "R4", -1, 0);
        send_byte(8'h04, "R4", -1, 0);
        send_byte(8'h55, "R4", -1, 0);
        bus_stop();
        bus_start();
        send_byte(8'h81, "R4", -1, 0);
        send_byte(8'h04, "R4", -1, 0);
        bus_stop();
        chk("R4", regs_o[4*8 +: 8], 8'hE7);

        // R3 with strap high
        strap = 1'b1;
        cur_req = "R3";
        bus_start();
        send_byte(8'h82, "R3", -1, 0);
        send_byte(8'h04, "R3", -1, 0);
        send_byte(8'h3C, "R3", -1, 0);
        bus_stop();
        chk("R3", regs_o[4*8 +: 8], 8'h3C);
        strap = 1'b0;

        // R9: STOP mid byte, then repeated START mid byte
        cur_req = "R9";
        bus_start();
        send_byte(8'h80, "R9", -1, 0);
        send_byte(8'h07, "R9", -1, 0);
        send_bits(8'hFF, 4);
        bus_stop();
        chk("R9", regs_o[7*8 +: 8], 8'h58);
        bus_start();
        send_byte(8'h80, "R9", -1, 0);
        send_byte(8'h07, "R9", -1, 0);
        send_bits(8'h00, 5);
        bus_rep_start();
        send_byte(8'h80, "R9", -1, 0);
        send_byte(8'h06, "R9", -1, 0);
        send_byte(8'h21, "R9", -1, 0);
        bus_stop();
        chk("R9", regs_o[7*8 +: 8], 8'h58);
        chk("R9", regs_o[6*8 +: 8], 8'h21);

        // R10: one-clock pulses on SDA (SCL high) and SCL
        cur_req = "R10";
        bus_start();
        send_byte(8'h80, "R10", -1, 0);
        send_byte(8'h09, "R10", 3, 1);
        send_byte(8'h5B, "R10", 5, 1);
        send_byte(8'h6C, "R10", 2, 2);
        bus_stop();
        chk("R10", regs_o[9*8 +: 8], 8'h6C);

        wclk(20);
        finish_run();
    end
endmodule